// File: doc/BRIEF.md
# Quadrature Up/Down Position Counter

This block tracks the position of a rotary encoder, a manual thumbwheel or any pair of count pulses in a 32-bit signed register. Two phase inputs can be decoded as a Gray-coded quadrature pair or as a plain two-bit binary code. The same pins also serve two general-purpose modes. In one, a level selects the direction and edges on the other pin count. In the other, each pin counts in its own direction. A third input carries a zero marker that either clears the position or only reports a push-button event.

All three inputs are first synchronised and then filtered by a debouncer. The debounce length is set as a power of two. Upper and lower bound values are compared against the count on every step. In warning mode, crossing a bound raises an interrupt pulse. In auto-zero mode, reaching a bound reloads the count with zero. Each accepted step also drives a one-cycle event pulse, which a companion timer can use to measure the time between steps.

Top module: `quad_updown_counter`

## Requirements
- R1: After reset the count is 0 and every pulse output (`cnt_evt_o`, `err_o`, `zm_evt_o`, `irq_max_o`, `irq_min_o`) is low.
- R2: With `cfg_mode` = 0 (quadrature), the debounced code {A,B} advancing 00→01→11→10→00 counts up by one per change, and the reverse order counts down.
- R3: With `cfg_mode` = 1 (binary), the debounced code {A,B} read as an unsigned 2-bit value counts up when it rises by one modulo 4, and counts down when it falls by one modulo 4.
- R4: In modes 0 and 1, a change of two positions (quadrature) or two values (binary) pulses `err_o` for one cycle and leaves the count unchanged.
- R5: With `cfg_mode` = 2 (direction), a rising debounced edge on B counts up when A is 1 and counts down when A is 0.
- R6: With `cfg_mode` = 3 (up/down), a rising debounced edge on A counts up and a rising edge on B counts down. Rising edges on both in the same cycle leave the count unchanged.
- R7: Each input takes a new debounced value only after its synchronised level has differed from the current value for 2^`cfg_dbn` consecutive clocks. A shorter pulse has no effect on the count.
- R8: Every accepted up or down step raises `cnt_evt_o` for exactly one cycle. The count never changes without that pulse, except when it is cleared to zero.
- R9: A rising debounced edge on Z raises `zm_evt_o` for one cycle. When `cfg_zclr` is 1, that same edge also loads the count with 0, which takes priority over a step in that cycle and suppresses its bound interrupts.
- R10: With `cfg_auto` = 1, an up step while count ≥ `cfg_max` loads 0 and pulses `irq_max_o`. A down step while count ≤ `cfg_min` loads 0 and pulses `irq_min_o`.
- R11: With `cfg_auto` = 0, an up step from exactly `cfg_max` gives `cfg_max`+1 and pulses `irq_max_o`. A down step from exactly `cfg_min` gives `cfg_min`−1 and pulses `irq_min_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_a | input | 1 | Raw phase A / direction level / up pulse |
| in_b | input | 1 | Raw phase B / count pulse / down pulse |
| in_z | input | 1 | Raw zero marker or push-button |
| cfg_mode | input | 2 | 0 quadrature, 1 binary, 2 direction, 3 up/down |
| cfg_dbn | input | 3 | Debounce exponent: filter length 2^cfg_dbn clocks |
| cfg_zclr | input | 1 | 1: zero marker clears the count |
| cfg_auto | input | 1 | 1: auto-zero at bounds, 0: warning interrupts |
| cfg_max | input | 32 | Signed upper bound |
| cfg_min | input | 32 | Signed lower bound |
| cnt_o | output | 32 | Signed position count |
| cnt_evt_o | output | 1 | One-cycle pulse per accepted step |
| err_o | output | 1 | One-cycle pulse on an illegal code change |
| zm_evt_o | output | 1 | One-cycle pulse on a zero-marker edge |
| irq_max_o | output | 1 | Upper bound interrupt pulse |
| irq_min_o | output | 1 | Lower bound interrupt pulse |

## Verification
The assertions watch several rules on every cycle. A filtered input may only move toward its synchronised level. The count never moves without a step pulse or a clear. An illegal code leaves the count alone. A bound pulse yields zero in auto-zero mode and bound plus one in warning mode. Other behaviour needs the bench's scenarios, where a cycle-accurate reference model runs alongside the design. These include the exact Gray and binary orderings, the step direction in the two general-purpose modes, the cancelling of simultaneous edges, the rejection of glitches shorter than the filter length, and the priority of the zero clear over a step.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_BIN  = 2'd1,
        MODE_DIR  = 2'd2,
        MODE_UPDN = 2'd3
    } qmode_e;

    // position of a two-bit code along the quadrature cycle 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

endpackage

// File: rtl/qcnt_debounce.sv
module qcnt_debounce #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             clean_o
);
    localparam int CW = 1 << SEL_W;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          out;
        logic [CW-1:0] run;
    } db_t;

    db_t st_q, st_d;
    logic [CW-1:0] last_run;

    always_comb begin
        last_run = (CW'(1) << sel_i) - CW'(1);
        st_d     = st_q;
        st_d.s1  = raw_i;
        st_d.s2  = st_q.s1;
        if (st_q.s2 != st_q.out) begin
            if (st_q.run == last_run) begin
                st_d.out = st_q.s2;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + CW'(1);
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean_o = st_q.out;

    // R7: filtered value only ever moves to the synchronised level
    p_db_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out != $past(st_q.out)) |-> (st_q.out == $past(st_q.s2)));

endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       err_o
);
    typedef struct packed {
        logic a;
        logic b;
    } prev_t;

    prev_t pv_q, pv_d;
    logic [1:0] pos_now, pos_old, delta;
    logic       rise_a, rise_b;

    always_comb begin
        pv_d.a = a_i;
        pv_d.b = b_i;

        if (mode_i == MODE_BIN) begin
            pos_now = {a_i, b_i};
            pos_old = {pv_q.a, pv_q.b};
        end else begin
            pos_now = gray_pos(a_i, b_i);
            pos_old = gray_pos(pv_q.a, pv_q.b);
        end
        delta  = pos_now - pos_old;
        rise_a = a_i & ~pv_q.a;
        rise_b = b_i & ~pv_q.b;

        up_o  = 1'b0;
        dn_o  = 1'b0;
        err_o = 1'b0;
        unique case (qmode_e'(mode_i))
            MODE_QUAD, MODE_BIN: begin
                up_o  = (delta == 2'd1);
                dn_o  = (delta == 2'd3);
                err_o = (delta == 2'd2);
            end
            MODE_DIR: begin
                up_o = rise_b & a_i;
                dn_o = rise_b & ~a_i;
            end
            MODE_UPDN: begin
                up_o = rise_a & ~rise_b;
                dn_o = rise_b & ~rise_a;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= '0;
        else        pv_q <= pv_d;
    end

    // R4: illegal code changes are only reported in the two code modes
    p_err_code_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (mode_i == MODE_QUAD || mode_i == MODE_BIN));

endmodule

// File: rtl/quad_updown_counter.sv
module quad_updown_counter #(
    parameter int CNT_W = 32,
    parameter int DB_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_a,
    input  logic                    in_b,
    input  logic                    in_z,
    input  logic [1:0]              cfg_mode,
    input  logic [DB_W-1:0]         cfg_dbn,
    input  logic                    cfg_zclr,
    input  logic                    cfg_auto,
    input  logic signed [CNT_W-1:0] cfg_max,
    input  logic signed [CNT_W-1:0] cfg_min,
    output logic signed [CNT_W-1:0] cnt_o,
    output logic                    cnt_evt_o,
    output logic                    err_o,
    output logic                    zm_evt_o,
    output logic                    irq_max_o,
    output logic                    irq_min_o
);
    localparam int NIN = 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             evt;
        logic             err;
        logic             zm;
        logic             imax;
        logic             imin;
        logic             zprev;
    } cnt_t;

    logic [NIN-1:0] raw_vec, db_vec;
    logic           step_up, step_dn, code_err, rise_z;
    cnt_t           st_q, st_d;

    assign raw_vec = {in_z, in_b, in_a};

    for (genvar gi = 0; gi < NIN; gi++) begin : g_filt
        qcnt_debounce #(.SEL_W(DB_W)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_vec[gi]),
            .sel_i   (cfg_dbn),
            .clean_o (db_vec[gi])
        );
    end

    qcnt_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (cfg_mode),
        .a_i    (db_vec[0]),
        .b_i    (db_vec[1]),
        .up_o   (step_up),
        .dn_o   (step_dn),
        .err_o  (code_err)
    );

    assign rise_z = db_vec[2] & ~st_q.zprev;

    always_comb begin
        st_d       = st_q;
        st_d.evt   = step_up | step_dn;
        st_d.err   = code_err;
        st_d.zm    = rise_z;
        st_d.zprev = db_vec[2];
        st_d.imax  = 1'b0;
        st_d.imin  = 1'b0;

        if (step_up) begin
            if (cfg_auto && ($signed(st_q.cnt) >= cfg_max)) begin
                st_d.cnt  = '0;
                st_d.imax = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + CNT_W'(1);
                st_d.imax = !cfg_auto && ($signed(st_q.cnt) == cfg_max);
            end
        end else if (step_dn) begin
            if (cfg_auto && ($signed(st_q.cnt) <= cfg_min)) begin
                st_d.cnt  = '0;
                st_d.imin = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                st_d.imin = !cfg_auto && ($signed(st_q.cnt) == cfg_min);
            end
        end

        if (rise_z && cfg_zclr) begin
            st_d.cnt  = '0;
            st_d.imax = 1'b0;
            st_d.imin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = $signed(st_q.cnt);
    assign cnt_evt_o = st_q.evt;
    assign err_o     = st_q.err;
    assign zm_evt_o  = st_q.zm;
    assign irq_max_o = st_q.imax;
    assign irq_min_o = st_q.imin;

    // R8: the count moves only with a step pulse or a clear to zero
    p_move_needs_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |-> (st_q.evt || st_q.cnt == '0));

    // R4: an illegal code change leaves the count where it was
    p_err_holds_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == '0));

    // R10: in auto-zero mode a bound pulse comes with a zero count
    p_auto_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.imax || st_q.imin) && $past(cfg_auto)) |-> (st_q.cnt == '0));

    // R11: in warning mode the upper pulse marks the step past the bound
    p_warn_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.imax && !$past(cfg_auto)) |->
        (st_q.cnt == $past(cfg_max) + CNT_W'(1)));

    // R11: both bound pulses never fire together
    p_bound_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.imax, st_q.imin}));

endmodule

// File: tb/tb_quad_updown_counter.sv
module tb_quad_updown_counter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_z = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [2:0] cfg_dbn = 3'd0;
    logic cfg_zclr = 1'b0, cfg_auto = 1'b0;
    logic signed [31:0] cfg_max = 32'sd1000;
    logic signed [31:0] cfg_min = -32'sd1000;
    logic signed [31:0] cnt_o;
    logic cnt_evt_o, err_o, zm_evt_o, irq_max_o, irq_min_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    always #2 clk = ~clk;

    quad_updown_counter dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
        .cfg_mode(cfg_mode), .cfg_dbn(cfg_dbn), .cfg_zclr(cfg_zclr),
        .cfg_auto(cfg_auto), .cfg_max(cfg_max), .cfg_min(cfg_min),
        .cnt_o(cnt_o), .cnt_evt_o(cnt_evt_o), .err_o(err_o),
        .zm_evt_o(zm_evt_o), .irq_max_o(irq_max_o), .irq_min_o(irq_min_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_sync1[3], m_sync2[3], m_run[3], m_clean[3];
    int m_pa, m_pb, m_pz;
    int m_cnt, m_evt, m_err, m_zm, m_imax, m_imin;

    function automatic int qpos(input int a, input int b);
        int tbl[4] = '{0, 1, 3, 2};
        return tbl[a*2 + b];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_sync1[i] = 0; m_sync2[i] = 0; m_run[i] = 0; m_clean[i] = 0;
        end
        m_pa = 0; m_pb = 0; m_pz = 0;
        m_cnt = 0; m_evt = 0; m_err = 0; m_zm = 0; m_imax = 0; m_imin = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int a, b, z, up, dn, bad, diff, raw[3];
            a = m_clean[0]; b = m_clean[1]; z = m_clean[2];
            up = 0; dn = 0; bad = 0;
            case (cfg_mode)
                2'd0, 2'd1: begin
                    if (cfg_mode == 2'd0) diff = (qpos(a, b) - qpos(m_pa, m_pb) + 4) % 4;
                    else                  diff = ((a*2 + b) - (m_pa*2 + m_pb) + 4) % 4;
                    up = (diff == 1); dn = (diff == 3); bad = (diff == 2);
                end
                2'd2: if (b && !m_pb) begin up = a; dn = !a; end
                default: begin
                    up = (a && !m_pa) && !(b && !m_pb);
                    dn = (b && !m_pb) && !(a && !m_pa);
                end
            endcase
            m_evt = up | dn; m_err = bad; m_zm = z && !m_pz;
            m_imax = 0; m_imin = 0;
            if (up) begin
                if (cfg_auto && m_cnt >= cfg_max) begin m_cnt = 0; m_imax = 1; end
                else begin m_imax = !cfg_auto && m_cnt == cfg_max; m_cnt = m_cnt + 1; end
            end else if (dn) begin
                if (cfg_auto && m_cnt <= cfg_min) begin m_cnt = 0; m_imin = 1; end
                else begin m_imin = !cfg_auto && m_cnt == cfg_min; m_cnt = m_cnt - 1; end
            end
            if (m_zm && cfg_zclr) begin m_cnt = 0; m_imax = 0; m_imin = 0; end
            m_pa = a; m_pb = b; m_pz = z;
            raw[0] = in_a; raw[1] = in_b; raw[2] = in_z;
            for (int i = 0; i < 3; i++) begin
                if (m_sync2[i] != m_clean[i]) begin
                    if (m_run[i] + 1 >= (1 << cfg_dbn)) begin
                        m_clean[i] = m_sync2[i]; m_run[i] = 0;
                    end else m_run[i] = m_run[i] + 1;
                end else m_run[i] = 0;
                m_sync2[i] = m_sync1[i];
                m_sync1[i] = raw[i];
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("count", int'(cnt_o), m_cnt);
            chk("step pulse", int'(cnt_evt_o), m_evt);
            chk("error pulse", int'(err_o), m_err);
            chk("marker pulse", int'(zm_evt_o), m_zm);
            chk("upper irq", int'(irq_max_o), m_imax);
            chk("lower irq", int'(irq_min_o), m_imin);
        end
    end

    task automatic put(input logic a, input logic b, input logic z, input int n);
        @(negedge clk);
        in_a = a; in_b = b; in_z = z;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic clear_count();
        cfg_zclr = 1'b1;
        put(in_a, in_b, 1'b1, 8);
        put(in_a, in_b, 1'b0, 8);
        cfg_zclr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired during %s", cur_req);
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk("reset count", int'(cnt_o), 0);
        chk("reset pulses", int'({cnt_evt_o, err_o, zm_evt_o, irq_max_o, irq_min_o}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: quadrature up then down
        cur_req = "R2"; cfg_mode = 2'd0;
        put(0,1,0,6); put(1,1,0,6); put(1,0,0,6); put(0,0,0,6);
        chk("quad up four", int'(cnt_o), 4);
        put(1,0,0,6); put(1,1,0,6); put(0,1,0,6); put(0,0,0,6);
        put(1,0,0,6);
        chk("quad down five", int'(cnt_o), -1);
        put(0,0,0,6);

        // R3: binary code steps
        cur_req = "R3"; cfg_mode = 2'd1;
        put(0,1,0,6); put(1,0,0,6); put(1,1,0,6); put(0,0,0,6);
        chk("binary up wrap", int'(cnt_o), 4);
        put(1,1,0,6); put(1,0,0,6);
        chk("binary down", int'(cnt_o), 2);

        // R4: two-step jumps in both code modes
        cur_req = "R4";
        put(0,0,0,6);
        chk("binary jump holds", int'(cnt_o), 2);
        cfg_mode = 2'd0;
        put(1,1,0,6);
        chk("quad jump holds", int'(cnt_o), 2);
        put(0,0,0,6);

        // R5: direction mode
        cur_req = "R5"; cfg_mode = 2'd2;
        put(1,0,0,6); put(1,1,0,6); put(1,0,0,6); put(1,1,0,6);
        put(0,0,0,6); put(0,1,0,6); put(0,0,0,6);
        chk("direction net", int'(cnt_o), 3);

        // R6: up/down pulse mode incl. simultaneous edges
        cur_req = "R6"; cfg_mode = 2'd3;
        put(1,0,0,6); put(0,0,0,6); put(0,1,0,6); put(0,0,0,6); put(0,1,0,6); put(0,0,0,6);
        put(1,1,0,6);
        chk("simultaneous cancel", int'(cnt_o), 2);
        put(0,0,0,6);

        // R7: debounce length 8, glitch of 5 ignored, long level accepted
        cur_req = "R7"; cfg_dbn = 3'd3;
        put(1,0,0,5); put(0,0,0,20);
        chk("glitch ignored", int'(cnt_o), 2);
        put(1,0,0,20); put(0,0,0,20);
        chk("long pulse counted", int'(cnt_o), 3);
        cfg_dbn = 3'd0;
        put(0,0,0,6);

        // R8: step pulse checked each cycle by the model compare
        cur_req = "R8";
        put(1,0,0,6); put(0,0,0,6);

        // R9: marker as event only, then as clear
        cur_req = "R9";
        put(0,0,1,6); put(0,0,0,6);
        chk("marker no clear", int'(cnt_o), 4);
        clear_count();
        chk("marker clear", int'(cnt_o), 0);
        cfg_zclr = 1'b1;
        put(1,0,1,6); put(0,0,0,6);
        chk("clear beats step", int'(cnt_o), 0);
        cfg_zclr = 1'b0;

        // R10: auto-zero at both bounds
        cur_req = "R10"; cfg_auto = 1'b1; cfg_max = 32'sd3; cfg_min = -32'sd2;
        for (int k = 0; k < 4; k++) begin put(1,0,0,6); put(0,0,0,6); end
        chk("auto zero upper", int'(cnt_o), 0);
        for (int k = 0; k < 3; k++) begin put(0,1,0,6); put(0,0,0,6); end
        chk("auto zero lower", int'(cnt_o), 0);

        // R11: warning mode crossing both bounds
        cur_req = "R11"; cfg_auto = 1'b0;
        for (int k = 0; k < 5; k++) begin put(1,0,0,6); put(0,0,0,6); end
        chk("warn passes upper", int'(cnt_o), 5);
        for (int k = 0; k < 9; k++) begin put(0,1,0,6); put(0,0,0,6); end
        chk("warn passes lower", int'(cnt_o), -4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule